// File: doc/BRIEF.md
# Serial RGB LED Waveform Generator

This block drives a chain of addressable RGB LEDs over one wire. Software or a DMA engine writes 32-bit pixel words into a data register that feeds a 32-entry transmit FIFO. A write-1 start bit in the control register begins a frame. The block then shifts out 24 colour bits per LED. Each bit is a high phase followed by a low phase, and the block has separately programmable high and low times for a 0 bit and for a 1 bit, all counted in module-clock cycles.

After the last LED of the frame, the line is held low for a programmable reset interval. The block then sets a frame-done status bit, which can drive the interrupt line. A DMA request stays asserted while the FIFO level is at or below a programmable trigger level. The trigger level should be at least the DMA burst length; half the FIFO depth is the intended setting. If the FIFO runs dry in the middle of a frame, the frame is abandoned, the line stays low and an underflow status bit is set.

The register port is a simple single-cycle write strobe with a word index; read data is combinational on the index.

Top module: `ledwave_gen`

## Requirements
- R1: A 0 bit is sent as HI0 cycles high then LO0 cycles low, and a 1 bit as HI1 cycles high then LO1 cycles low. A programmed value of zero lasts one cycle. Consecutive bits and consecutive LEDs follow each other with no extra cycles.
- R2: The timing register (index 1) holds LO0 in bits [5:0], HI0 in [11:6], LO1 in [20:16] and HI1 in [26:21]. The frame register (index 2) holds the LED count minus one in [9:0] and the reset length in cycles in [31:16]. After reset these hold 336/P, 840/P, 882/P and 294/P (HI0, LO0, HI1, LO1), a reset length of 300000/P and an LED count of one, where P is the clock period in ns (parameter, default 42).
- R3: For each pixel word, bits [23:0] are sent most significant bit first, which gives the fixed order green [23:16], red [15:8], blue [7:0]. Bits [31:24] are ignored.
- R4: After the last LED's final low phase, the line stays low for the reset length (zero counts as one cycle). The done flag (status index 4, bit 0) is then set, the block returns to idle, and the line idles low.
- R5: The interrupt output equals done AND global enable (control index 0, bit 1) AND done enable (control bit 2). Writing 1 to status bit 0 clears done.
- R6: A write to the data register (index 5) pushes bits [23:0] into a 32-entry FIFO. A write when the FIFO is full is dropped. The FIFO level reads back in status bits [13:8].
- R7: The DMA request is high exactly when the FIFO level is at or below the trigger level (index 3, bits [5:0]; reset value is half the FIFO depth).
- R8: If a word is needed (at start or at an LED boundary) and the FIFO is empty, the frame ends at once with the line low. Underflow (status bit 1, write-1 clear) is set and done is not set.
- R9: Writing 1 to control bit 0 starts a frame when the block is idle. The start bit is ignored while a frame is running. Control bit 3 reads 1 while a frame runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; all timing counts use it |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| dma_req | output | 1 | FIFO refill request for a DMA engine |
| irq | output | 1 | Frame-done interrupt |
| led_out | output | 1 | Serial LED data line |

## Verification
The assertions assume that the bus write strobe is never left undefined, and that the FIFO pop request comes only from the bit engine, which checks for an empty FIFO first. They also assume that done and underflow rise only on the engine's completion and abort events. The stimulus always drives the strobe to a known level, makes every write last one cycle between falling edges, and changes timing registers only while the engine is idle. Mid-frame stimulus is limited to an extra start write, which must leave the waveform unchanged.

// File: rtl/ledwave_pkg.sv
package ledwave_pkg;
    localparam int WORD_W    = 32;
    localparam int PIX_W     = 24;
    localparam int BIT_IDX_W = $clog2(PIX_W);

    localparam int LO0_LSB = 0;
    localparam int LO0_W   = 6;
    localparam int HI0_LSB = 6;
    localparam int HI0_W   = 6;
    localparam int LO1_LSB = 16;
    localparam int LO1_W   = 5;
    localparam int HI1_LSB = 21;
    localparam int HI1_W   = 6;

    localparam int IDX_W   = 10;
    localparam int RST_LSB = 16;
    localparam int RST_W   = 16;
    localparam int TIM_W   = RST_W;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_BITT  = 3'd1;
    localparam logic [2:0] RA_FRAME = 3'd2;
    localparam logic [2:0] RA_FCFG  = 3'd3;
    localparam logic [2:0] RA_STAT  = 3'd4;
    localparam logic [2:0] RA_DATA  = 3'd5;

    typedef struct packed {
        logic [HI1_W-1:0] hi1;
        logic [LO1_W-1:0] lo1;
        logic [HI0_W-1:0] hi0;
        logic [LO0_W-1:0] lo0;
    } bit_timing_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIGH  = 2'd1,
        ST_LOW   = 2'd2,
        ST_RESET = 2'd3
    } ser_state_e;
endpackage

// File: rtl/ledwave_fifo.sv
module ledwave_fifo #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic [LVL_W-1:0] level_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] wr_ptr;
        logic [LVL_W-1:0] count;
    } fifo_t;

    fifo_t f_d, f_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign empty_o = (f_q.count == '0);
    assign full_o  = (f_q.count == LVL_W'(DEPTH));
    assign level_o = f_q.count;
    assign head_o  = mem_q[f_q.rd_ptr];

    always_comb begin
        f_d     = f_q;
        push_ok = push_i && !full_o;
        pop_ok  = pop_i && !empty_o;
        if (push_ok) begin
            f_d.wr_ptr = (f_q.wr_ptr == LAST_PTR) ? '0 : f_q.wr_ptr + 1'b1;
        end
        if (pop_ok) begin
            f_d.rd_ptr = (f_q.rd_ptr == LAST_PTR) ? '0 : f_q.rd_ptr + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   f_d.count = f_q.count + 1'b1;
            2'b01:   f_d.count = f_q.count - 1'b1;
            default: f_d.count = f_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[f_q.wr_ptr] <= push_data_i;
        end
    end

    // R6
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.count <= LVL_W'(DEPTH));

    // R6
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (f_q.count != '0));
endmodule

// File: rtl/ledwave_serial.sv
module ledwave_serial
    import ledwave_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  bit_timing_t       timing_i,
    input  logic [IDX_W-1:0]  last_idx_i,
    input  logic [RST_W-1:0]  rst_len_i,
    input  logic              fifo_empty_i,
    input  logic [PIX_W-1:0]  fifo_head_i,
    output logic              pop_o,
    output logic              line_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              underflow_o
);
    localparam logic [BIT_IDX_W-1:0] TOP_BIT = BIT_IDX_W'(PIX_W - 1);

    typedef struct packed {
        ser_state_e           state;
        logic [TIM_W-1:0]     cnt;
        logic [PIX_W-1:0]     shreg;
        logic [BIT_IDX_W-1:0] bit_idx;
        logic [IDX_W-1:0]     pix;
        logic                 line;
    } ser_t;

    localparam ser_t SER_RST = '{state: ST_IDLE, cnt: '0, shreg: '0,
                                 bit_idx: '0, pix: '0, line: 1'b0};

    ser_t s_d, s_q;

    function automatic logic [TIM_W-1:0] phase_len(input logic [TIM_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    function automatic logic [TIM_W-1:0] high_len(input logic b, input bit_timing_t t);
        return phase_len(b ? TIM_W'(t.hi1) : TIM_W'(t.hi0));
    endfunction

    function automatic logic [TIM_W-1:0] low_len(input logic b, input bit_timing_t t);
        return phase_len(b ? TIM_W'(t.lo1) : TIM_W'(t.lo0));
    endfunction

    always_comb begin
        s_d         = s_q;
        pop_o       = 1'b0;
        done_o      = 1'b0;
        underflow_o = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (fifo_empty_i) begin
                        underflow_o = 1'b1;
                    end else begin
                        pop_o       = 1'b1;
                        s_d.shreg   = fifo_head_i;
                        s_d.bit_idx = TOP_BIT;
                        s_d.pix     = '0;
                        s_d.cnt     = high_len(fifo_head_i[PIX_W-1], timing_i);
                        s_d.state   = ST_HIGH;
                    end
                end
            end
            ST_HIGH: begin
                if (s_q.cnt == '0) begin
                    s_d.cnt   = low_len(s_q.shreg[PIX_W-1], timing_i);
                    s_d.state = ST_LOW;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_LOW: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (s_q.bit_idx != '0) begin
                    s_d.shreg   = {s_q.shreg[PIX_W-2:0], 1'b0};
                    s_d.bit_idx = s_q.bit_idx - 1'b1;
                    s_d.cnt     = high_len(s_q.shreg[PIX_W-2], timing_i);
                    s_d.state   = ST_HIGH;
                end else if (s_q.pix == last_idx_i) begin
                    s_d.cnt   = phase_len(rst_len_i);
                    s_d.state = ST_RESET;
                end else if (fifo_empty_i) begin
                    underflow_o = 1'b1;
                    s_d.state   = ST_IDLE;
                end else begin
                    pop_o       = 1'b1;
                    s_d.shreg   = fifo_head_i;
                    s_d.bit_idx = TOP_BIT;
                    s_d.pix     = s_q.pix + 1'b1;
                    s_d.cnt     = high_len(fifo_head_i[PIX_W-1], timing_i);
                    s_d.state   = ST_HIGH;
                end
            end
            ST_RESET: begin
                if (s_q.cnt == '0) begin
                    done_o    = 1'b1;
                    s_d.state = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
        s_d.line = (s_d.state == ST_HIGH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= SER_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_o = s_q.line;
    assign busy_o = (s_q.state != ST_IDLE);

    // R8
    uf_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> (!busy_o && !line_o));
endmodule

// File: rtl/ledwave_regs.sv
module ledwave_regs
    import ledwave_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int CLK_NS = 42,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [2:0]        addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    input  logic [LVL_W-1:0]  level_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              underflow_i,
    output logic              start_o,
    output logic              push_o,
    output bit_timing_t       timing_o,
    output logic [IDX_W-1:0]  last_idx_o,
    output logic [RST_W-1:0]  rst_len_o,
    output logic              irq_o,
    output logic              dma_req_o
);
    localparam int DEF_HI0 = 336 / CLK_NS;
    localparam int DEF_LO0 = 840 / CLK_NS;
    localparam int DEF_HI1 = 882 / CLK_NS;
    localparam int DEF_LO1 = 294 / CLK_NS;
    localparam int DEF_RST = 300000 / CLK_NS;

    typedef struct packed {
        logic             gie;
        logic             die;
        bit_timing_t      timing;
        logic [IDX_W-1:0] last_idx;
        logic [RST_W-1:0] rst_len;
        logic [LVL_W-1:0] trig;
        logic             done;
        logic             uf;
    } regs_t;

    localparam regs_t REGS_RST = '{
        gie: 1'b0, die: 1'b0,
        timing: '{hi1: HI1_W'(DEF_HI1), lo1: LO1_W'(DEF_LO1),
                  hi0: HI0_W'(DEF_HI0), lo0: LO0_W'(DEF_LO0)},
        last_idx: '0, rst_len: RST_W'(DEF_RST),
        trig: LVL_W'(DEPTH / 2), done: 1'b0, uf: 1'b0};

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        start_o = 1'b0;
        push_o  = 1'b0;
        if (wr_i) begin
            case (addr_i)
                RA_CTRL: begin
                    start_o = wdata_i[0];
                    r_d.gie = wdata_i[1];
                    r_d.die = wdata_i[2];
                end
                RA_BITT: begin
                    r_d.timing.lo0 = wdata_i[LO0_LSB +: LO0_W];
                    r_d.timing.hi0 = wdata_i[HI0_LSB +: HI0_W];
                    r_d.timing.lo1 = wdata_i[LO1_LSB +: LO1_W];
                    r_d.timing.hi1 = wdata_i[HI1_LSB +: HI1_W];
                end
                RA_FRAME: begin
                    r_d.last_idx = wdata_i[IDX_W-1:0];
                    r_d.rst_len  = wdata_i[RST_LSB +: RST_W];
                end
                RA_FCFG: r_d.trig = wdata_i[LVL_W-1:0];
                RA_STAT: begin
                    if (wdata_i[0]) r_d.done = 1'b0;
                    if (wdata_i[1]) r_d.uf   = 1'b0;
                end
                RA_DATA: push_o = 1'b1;
                default: ;
            endcase
        end
        if (done_i)      r_d.done = 1'b1;
        if (underflow_i) r_d.uf   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            RA_CTRL: begin
                rdata_o[1] = r_q.gie;
                rdata_o[2] = r_q.die;
                rdata_o[3] = busy_i;
            end
            RA_BITT: begin
                rdata_o[LO0_LSB +: LO0_W] = r_q.timing.lo0;
                rdata_o[HI0_LSB +: HI0_W] = r_q.timing.hi0;
                rdata_o[LO1_LSB +: LO1_W] = r_q.timing.lo1;
                rdata_o[HI1_LSB +: HI1_W] = r_q.timing.hi1;
            end
            RA_FRAME: begin
                rdata_o[IDX_W-1:0]        = r_q.last_idx;
                rdata_o[RST_LSB +: RST_W] = r_q.rst_len;
            end
            RA_FCFG: rdata_o[LVL_W-1:0] = r_q.trig;
            RA_STAT: begin
                rdata_o[0]          = r_q.done;
                rdata_o[1]          = r_q.uf;
                rdata_o[8 +: LVL_W] = level_i;
            end
            default: rdata_o = '0;
        endcase
    end

    assign timing_o   = r_q.timing;
    assign last_idx_o = r_q.last_idx;
    assign rst_len_o  = r_q.rst_len;
    assign irq_o      = r_q.done && r_q.gie && r_q.die;
    assign dma_req_o  = (level_i <= r_q.trig);

    // R4
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.done) |-> $past(done_i));

    // R5
    done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.done) |-> $past(wr_i && addr_i == RA_STAT && wdata_i[0]));

    // R8
    uf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.uf) |-> $past(underflow_i));
endmodule

// File: rtl/ledwave_gen.sv
module ledwave_gen
    import ledwave_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int CLK_NS     = 42
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        dma_req,
    output logic        irq,
    output logic        led_out
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic              start, push, pop, fifo_empty, fifo_full;
    logic              busy, frame_done, underflow;
    logic [PIX_W-1:0]  head;
    logic [LVL_W-1:0]  level;
    bit_timing_t       timing;
    logic [IDX_W-1:0]  last_idx;
    logic [RST_W-1:0]  rst_len;

    ledwave_regs #(.DEPTH(FIFO_DEPTH), .CLK_NS(CLK_NS), .LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .level_i(level),
        .busy_i(busy), .done_i(frame_done), .underflow_i(underflow),
        .start_o(start), .push_o(push), .timing_o(timing),
        .last_idx_o(last_idx), .rst_len_o(rst_len), .irq_o(irq),
        .dma_req_o(dma_req)
    );

    ledwave_fifo #(.WIDTH(PIX_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push),
        .push_data_i(bus_wdata[PIX_W-1:0]), .pop_i(pop), .head_o(head),
        .level_o(level), .empty_o(fifo_empty), .full_o(fifo_full)
    );

    ledwave_serial u_serial (
        .clk(clk), .rst_n(rst_n), .start_i(start), .timing_i(timing),
        .last_idx_i(last_idx), .rst_len_i(rst_len), .fifo_empty_i(fifo_empty),
        .fifo_head_i(head), .pop_o(pop), .line_o(led_out), .busy_o(busy),
        .done_o(frame_done), .underflow_o(underflow)
    );

    // R6
    full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> (level == LVL_W'(FIFO_DEPTH)));
endmodule

// File: tb/ledwave_gen_tb.sv
module ledwave_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        dma_req, irq, led_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic        exp_wave [0:4095];
    int          exp_len;
    int          bits_len;
    logic [31:0] words [0:7];
    int          hi0, lo0, hi1, lo1, rstl;

    always #4 clk = ~clk;

    ledwave_gen u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_req(dma_req),
        .irq(irq), .led_out(led_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_timing(input int h0, input int l0, input int h1, input int l1);
        hi0 = h0; lo0 = l0; hi1 = h1; lo1 = l1;
        wr(3'd1, (32'(h1) << 21) | (32'(l1) << 16) | (32'(h0) << 6) | 32'(l0));
    endtask

    task automatic build_wave(input int n);
        exp_len = 0;
        for (int w = 0; w < n; w++) begin
            for (int b = 23; b >= 0; b--) begin
                int h = words[w][b] ? hi1 : hi0;
                int l = words[w][b] ? lo1 : lo0;
                if (h == 0) h = 1;
                if (l == 0) l = 1;
                for (int k = 0; k < h; k++) begin exp_wave[exp_len] = 1'b1; exp_len++; end
                for (int k = 0; k < l; k++) begin exp_wave[exp_len] = 1'b0; exp_len++; end
            end
        end
        bits_len = exp_len;
        for (int k = 0; k < ((rstl == 0) ? 1 : rstl); k++) begin
            exp_wave[exp_len] = 1'b0; exp_len++;
        end
    endtask

    // Samples led_out once per cycle starting at the current falling edge.
    task automatic record(input int len, input int inject, input logic [31:0] ctrl,
                          output int mism, output int first_bad, output logic irq_last);
        mism = 0; first_bad = -1; irq_last = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (led_out !== exp_wave[i]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
            irq_last = irq;
            if (i == inject) begin
                bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = ctrl | 32'h1;
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
        end
        bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd1, v);
        check(v == ((32'(882/42) << 21) | (32'(294/42) << 16) | (32'(336/42) << 6) | 32'(840/42)),
              "R2", "timing reset value", v, 0);
        rd(3'd2, v);
        check(v == (32'(300000/42) << 16), "R2", "frame reset value", v, 32'(300000/42) << 16);
        rd(3'd3, v);
        check(v == 32'd16, "R7", "trigger reset value", v, 16);
        rd(3'd4, v);
        check(v == 32'd0, "R6", "status/level after reset", v, 0);
        check(led_out == 1'b0 && irq == 1'b0, "R4", "line and irq idle", {led_out, irq}, 0);
        check(dma_req == 1'b1, "R7", "dma_req with empty fifo", dma_req, 1);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        int mism, first_bad;
        logic irq_last;
        set_timing(2, 3, 4, 1);
        rstl = 5;
        wr(3'd2, (32'd5 << 16) | 32'd1);
        words[0] = 32'hDE_A5_3C_0F;
        words[1] = 32'h00_81_7E_01;
        wr(3'd5, words[0]);
        wr(3'd5, words[1]);
        build_wave(2);
        wr(3'd0, 32'h7);
        // R9: second start at sample 20 must not disturb the frame
        record(exp_len, 20, 32'h6, mism, first_bad, irq_last);
        check(mism == 0, "R1 R3 R9", "waveform mismatches (first index)", first_bad, -1);
        check(irq_last == 1'b0, "R4", "irq during reset interval", irq_last, 0);
        rd(3'd4, v);
        check(v[0] == 1'b1, "R4", "done after reset interval", v[0], 1);
        check(irq == 1'b1, "R5", "irq with both enables", irq, 1);
        check(led_out == 1'b0, "R4", "line idle after frame", led_out, 0);
        check(v[13:8] == 6'd0, "R6", "level after frame", v[13:8], 0);
        rd(3'd0, v);
        check(v[3] == 1'b0, "R9", "busy after frame", v[3], 0);
        wr(3'd4, 32'h1);
        rd(3'd4, v);
        check(v[0] == 1'b0 && irq == 1'b0, "R5", "done/irq after clear", {v[0], irq}, 0);
    endtask

    task automatic t_alt();
        logic [31:0] v;
        int mism, first_bad;
        logic irq_last;
        set_timing(1, 0, 3, 2);
        rstl = 0;
        wr(3'd2, 32'd0);
        wr(3'd0, 32'h2);
        words[0] = 32'h12_F0_0F_55;
        wr(3'd5, words[0]);
        build_wave(1);
        wr(3'd0, 32'h3);
        record(exp_len, -1, 32'h0, mism, first_bad, irq_last);
        check(mism == 0, "R1 R4", "zero-length phases waveform (first index)", first_bad, -1);
        rd(3'd4, v);
        check(v[0] == 1'b1 && irq == 1'b0, "R5", "done set but irq masked", {v[0], irq}, 2'b10);
        wr(3'd0, 32'h6);
        check(irq == 1'b1, "R5", "irq after enabling", irq, 1);
        rd(3'd0, v);
        check(v[3] == 1'b0, "R9", "ctrl write without start stays idle", v[3], 0);
        wr(3'd4, 32'h1);
        check(irq == 1'b0, "R5", "irq after clear", irq, 0);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        int mism, first_bad;
        logic irq_last;
        set_timing(1, 1, 1, 1);
        rstl = 3;
        wr(3'd2, (32'd3 << 16) | 32'd2);
        words[0] = 32'h00_C3_3C_99;
        wr(3'd5, words[0]);
        build_wave(1);
        wr(3'd0, 32'h1);
        record(bits_len, -1, 32'h0, mism, first_bad, irq_last);
        check(mism == 0, "R8", "waveform before underflow", first_bad, -1);
        rd(3'd4, v);
        check(v[1:0] == 2'b10, "R8", "underflow set, done clear", v[1:0], 2'b10);
        check(led_out == 1'b0, "R8", "line low after underflow", led_out, 0);
        repeat (10) @(negedge clk);
        rd(3'd4, v);
        check(v[0] == 1'b0 && led_out == 1'b0, "R8", "frame not resumed", {v[0], led_out}, 0);
        rd(3'd0, v);
        check(v[3] == 1'b0, "R8", "idle after underflow", v[3], 0);
        wr(3'd4, 32'h2);
        rd(3'd4, v);
        check(v[1] == 1'b0, "R8", "underflow cleared", v[1], 0);
        wr(3'd0, 32'h1);
        rd(3'd4, v);
        check(v[1:0] == 2'b10 && led_out == 1'b0, "R8", "start on empty fifo", v[1:0], 2'b10);
        wr(3'd4, 32'h3);
    endtask

    task automatic t_fifo_dma();
        logic [31:0] v;
        bit seen;
        wr(3'd3, 32'd4);
        rd(3'd3, v);
        check(v[5:0] == 6'd4, "R7", "trigger readback", v[5:0], 4);
        for (int i = 0; i < 4; i++) wr(3'd5, 32'h100 + 32'(i));
        rd(3'd4, v);
        check(v[13:8] == 6'd4, "R6", "level after 4 writes", v[13:8], 4);
        check(dma_req == 1'b1, "R7", "dma_req at trigger level", dma_req, 1);
        wr(3'd5, 32'h1FF);
        check(dma_req == 1'b0, "R7", "dma_req above trigger", dma_req, 0);
        for (int i = 0; i < 35; i++) wr(3'd5, 32'h200 + 32'(i));
        rd(3'd4, v);
        check(v[13:8] == 6'd32, "R6", "level saturates when full", v[13:8], 32);
        set_timing(1, 1, 1, 1);
        wr(3'd2, (32'd1 << 16) | 32'd31);
        wr(3'd0, 32'h1);
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            rd(3'd4, v);
            seen = v[0];
        end
        check(seen && v[1] == 1'b0, "R6", "32-LED frame drains fifo", v[1:0], 1);
        check(v[13:8] == 6'd0 && dma_req == 1'b1, "R7", "empty fifo requests", {v[13:8], dma_req}, 1);
        wr(3'd4, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 32'd0;
        rstl = 0; hi0 = 0; lo0 = 0; hi1 = 0; lo1 = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        @(negedge clk);
        t_basic();
        t_alt();
        t_underflow();
        t_fifo_dma();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule